// File: doc/BRIEF.md
# Redundant Memory Access Filter

This block wraps a single-port synchronous SRAM and drops memory enables for accesses that cannot change what the requester sees. A read is not sent to the array when its data will not be consumed, or when it repeats the address of the last forwarded read and no forwarded write has happened since. A write is not sent when it carries the same address and data as the last forwarded write. The requester always gets correct read data: a dropped read returns a held copy of the last read data, with the same one-cycle latency as a read that reaches the array.

The requester drives read and write strobes, one shared address, write data and an observe flag that says whether the read result will be used. The filtered chip-enable and write-enable going to the internal array are brought out as ports so the saving can be seen. Four event counters report forwarded and dropped reads and writes. If a read and a write are requested together, the write goes first and the read is carried out in the next cycle. A busy flag is high for that cycle, and any request presented then is not accepted.

Top module: `mem_access_filter`

## Requirements
- R1: After reset all four counters read zero, rsp_valid and busy are low, the last-read and last-write records are empty, and the first read and the first write are both forwarded (mem_ce high; mem_we high for the write).
- R2: A read with observe low does not drive mem_ce, produces no rsp_valid pulse, counts as a dropped read, and leaves the last-read record unchanged.
- R3: An observed read to the address of the last forwarded read is dropped (mem_ce low) if no write has been forwarded since that read.
- R4: Every forwarded write clears the last-read record, so the next observed read is forwarded whatever its address.
- R5: A write whose address and data both equal those of the last forwarded write is dropped (mem_ce and mem_we low).
- R6: A write is forwarded when its data differs from the last forwarded write, or when a different write was forwarded in between, even if an older write had the same address and data.
- R7: Every observed read, forwarded or dropped, raises rsp_valid in the cycle after it is serviced, and rsp_rdata then holds the array content at that address.
- R8: When read and write are requested in the same cycle, the write alone is forwarded in that cycle. busy is high in the next cycle, and in that cycle the read is serviced from the same address (mem_ce high, mem_we low). Its data appears one cycle later.
- R9: Requests presented while busy is high are not accepted; a write presented then does not change the array.
- R10: cnt_rd_fwd, cnt_rd_drop, cnt_wr_fwd and cnt_wr_drop each rise by exactly one for each read or write serviced in the matching way.
- R11: A dropped write does not clear the last-read record: a repeat read after it is still dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| req_addr | input | ADDR_W | Shared read/write address |
| req_wdata | input | DATA_W | Write data |
| req_observe | input | 1 | Read result will be consumed |
| rsp_valid | output | 1 | Read data valid this cycle |
| rsp_rdata | output | DATA_W | Read data |
| busy | output | 1 | Deferred read in progress; requests not accepted |
| mem_ce | output | 1 | Filtered chip-enable to the array |
| mem_we | output | 1 | Filtered write-enable to the array |
| cnt_rd_fwd | output | CNT_W | Forwarded reads |
| cnt_rd_drop | output | CNT_W | Dropped reads |
| cnt_wr_fwd | output | CNT_W | Forwarded writes |
| cnt_wr_drop | output | CNT_W | Dropped writes |

## Verification
A write and a read can be requested in the same cycle. The write then takes the port, clears the last-read record and defers the read. The bench provokes this twice by raising both strobes for one cycle. It judges the enables cycle by cycle: write-enable in the first cycle, a plain read in the busy cycle. It then checks that the deferred read returns the freshly written data instead of a held copy. In the second case a write is presented during the busy cycle, and a later forwarded read of that address shows the old content.

// File: rtl/mafl_pkg.sv
// Package: shared event indices for the redundant access filter.
// Assumes: one counter per event kind, indexed by this enum.
package mafl_pkg;
    typedef enum int {
        EV_RD_FWD  = 0,
        EV_RD_DROP = 1,
        EV_WR_FWD  = 2,
        EV_WR_DROP = 3
    } mafl_event_e;

    localparam int MAFL_NUM_EV = 4;
endpackage

// File: rtl/mafl_sram.sv
// Module: mafl_sram
// Behavioural single-port synchronous SRAM. When enabled, it writes (we=1)
// or registers a read into q (we=0). q holds its value while not reading.
// Assumes: array content is undefined until written.
module mafl_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Array write port.
    always_ff @(posedge clk) begin
        if (ce && we) begin
            mem[addr] <= wdata;
        end
    end

    // Registered read port, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ce && !we) begin
            q <= mem[addr];
        end
    end
endmodule

// File: rtl/mafl_read_filter.sv
// Module: mafl_read_filter
// Keeps the address of the last forwarded read. It decides whether the read
// serviced this cycle goes to the array or is dropped.
// Assumes: take_i and wr_evt_i are never high in the same cycle.
module mafl_read_filter #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              obs_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_evt_i,
    output logic              fwd_o,
    output logic              drop_o
);
    logic              rec_valid_q;
    logic [ADDR_W-1:0] rec_addr_q;
    logic              hit;

    // Repeat detection against the stored record.
    always_comb begin
        hit    = rec_valid_q && (rec_addr_q == addr_i);
        fwd_o  = take_i && obs_i && !hit;
        drop_o = take_i && !fwd_o;
    end

    // Record update: a forwarded write clears it, a forwarded read sets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid_q <= 1'b0;
            rec_addr_q  <= '0;
        end else if (wr_evt_i) begin
            rec_valid_q <= 1'b0;
        end else if (fwd_o) begin
            rec_valid_q <= 1'b1;
            rec_addr_q  <= addr_i;
        end
    end

    // R3: back-to-back observed read of the same address is dropped.
    assert_repeat_read_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && obs_i && $past(rst_n) && $past(fwd_o) && addr_i == $past(addr_i))
        |-> !fwd_o);

    // R4: a read right after a forwarded write always reaches the array.
    assert_write_clears_record_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_evt_i) && take_i && obs_i) |-> fwd_o);
endmodule

// File: rtl/mafl_write_filter.sv
// Module: mafl_write_filter
// Keeps the address and data of the last forwarded write and drops an
// identical repeat.
// Assumes: take_i marks the single write serviced this cycle.
module mafl_write_filter #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              fwd_o,
    output logic              drop_o
);
    logic              rec_valid_q;
    logic [ADDR_W-1:0] rec_addr_q;
    logic [DATA_W-1:0] rec_data_q;
    logic              hit;

    // Duplicate detection on address and data together.
    always_comb begin
        hit    = rec_valid_q && (rec_addr_q == addr_i) && (rec_data_q == data_i);
        fwd_o  = take_i && !hit;
        drop_o = take_i && hit;
    end

    // Record follows every forwarded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid_q <= 1'b0;
            rec_addr_q  <= '0;
            rec_data_q  <= '0;
        end else if (fwd_o) begin
            rec_valid_q <= 1'b1;
            rec_addr_q  <= addr_i;
            rec_data_q  <= data_i;
        end
    end

    // R5: an identical write straight after a forwarded one is dropped.
    assert_dup_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && $past(rst_n) && $past(fwd_o) && addr_i == $past(addr_i)
         && data_i == $past(data_i)) |-> !fwd_o);
endmodule

// File: rtl/mafl_event_counter.sv
// Module: mafl_event_counter
// Counts single-cycle event pulses; wraps at the width limit.
// Assumes: at most one event per cycle.
module mafl_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_i,
    output logic [CNT_W-1:0] cnt_o
);
    // Increment on each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (ev_i) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

    // R10: counter moves by at most one per cycle.
    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cnt_o - $past(cnt_o)) <= CNT_W'(1)));
endmodule

// File: rtl/mem_access_filter.sv
// Module: mem_access_filter
// Top of the redundant access filter. It arbitrates the request (write
// before read, collided read deferred by one cycle), runs the read and write
// filters, drives the internal SRAM, and returns read data from the array
// or from a held copy.
// Assumes: requests presented while busy is high are not accepted.
module mem_access_filter
    import mafl_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_observe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              mem_ce,
    output logic              mem_we,
    output logic [CNT_W-1:0]  cnt_rd_fwd,
    output logic [CNT_W-1:0]  cnt_rd_drop,
    output logic [CNT_W-1:0]  cnt_wr_fwd,
    output logic [CNT_W-1:0]  cnt_wr_drop
);
    initial begin
        assert_param_range: assert (ADDR_W >= 4 && ADDR_W <= 10 && DATA_W >= 8 && DATA_W <= 32)
            else $error("mem_access_filter: parameter out of range");
    end

    logic              busy_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              pend_obs_q;
    logic              collide;
    logic              wr_take;
    logic              rd_take;
    logic              rd_obs;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_fwd;
    logic              rd_drop;
    logic              wr_fwd;
    logic              wr_drop;
    logic [ADDR_W-1:0] sram_addr;
    logic [DATA_W-1:0] sram_q;
    logic              rsp_valid_q;
    logic              from_mem_q;
    logic [DATA_W-1:0] hold_q;
    logic [MAFL_NUM_EV-1:0] events;
    logic [CNT_W-1:0]  cnt_bank [MAFL_NUM_EV];

    // Arbitration: pending read owns the port while busy; otherwise write wins.
    always_comb begin
        collide = !busy_q && req_rd && req_wr;
        if (busy_q) begin
            wr_take = 1'b0;
            rd_take = 1'b1;
            rd_obs  = pend_obs_q;
            rd_addr = pend_addr_q;
        end else begin
            wr_take = req_wr;
            rd_take = req_rd && !req_wr;
            rd_obs  = req_observe;
            rd_addr = req_addr;
        end
    end

    // Deferred-read capture on a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            pend_addr_q <= '0;
            pend_obs_q  <= 1'b0;
        end else begin
            busy_q <= collide;
            if (collide) begin
                pend_addr_q <= req_addr;
                pend_obs_q  <= req_observe;
            end
        end
    end

    mafl_read_filter #(.ADDR_W(ADDR_W)) u_rd_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (rd_take),
        .obs_i    (rd_obs),
        .addr_i   (rd_addr),
        .wr_evt_i (wr_fwd),
        .fwd_o    (rd_fwd),
        .drop_o   (rd_drop)
    );

    mafl_write_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .take_i (wr_take),
        .addr_i (req_addr),
        .data_i (req_wdata),
        .fwd_o  (wr_fwd),
        .drop_o (wr_drop)
    );

    // Filtered memory controls.
    always_comb begin
        mem_ce    = rd_fwd || wr_fwd;
        mem_we    = wr_fwd;
        sram_addr = wr_take ? req_addr : rd_addr;
    end

    mafl_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (mem_ce),
        .we    (mem_we),
        .addr  (sram_addr),
        .wdata (req_wdata),
        .q     (sram_q)
    );

    // Response timing and held copy of the last array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            from_mem_q  <= 1'b0;
            hold_q      <= '0;
        end else begin
            rsp_valid_q <= rd_take && rd_obs;
            from_mem_q  <= rd_fwd;
            if (from_mem_q) begin
                hold_q <= sram_q;
            end
        end
    end

    // Output selection between fresh array data and the held copy.
    always_comb begin
        rsp_valid = rsp_valid_q;
        rsp_rdata = from_mem_q ? sram_q : hold_q;
        busy      = busy_q;
    end

    // Event vector for the counter bank.
    always_comb begin
        events             = '0;
        events[EV_RD_FWD]  = rd_fwd;
        events[EV_RD_DROP] = rd_drop;
        events[EV_WR_FWD]  = wr_fwd;
        events[EV_WR_DROP] = wr_drop;
    end

    for (genvar g = 0; g < MAFL_NUM_EV; g++) begin : g_cnt
        mafl_event_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .ev_i  (events[g]),
            .cnt_o (cnt_bank[g])
        );
    end

    // Counter outputs.
    always_comb begin
        cnt_rd_fwd  = cnt_bank[EV_RD_FWD];
        cnt_rd_drop = cnt_bank[EV_RD_DROP];
        cnt_wr_fwd  = cnt_bank[EV_WR_FWD];
        cnt_wr_drop = cnt_bank[EV_WR_DROP];
    end

    // R8: a collision leads to exactly one busy cycle.
    assert_collision_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_wr && !busy) |=> busy);
    assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R8: during busy only a read reaches the array.
    assert_busy_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we);

    // R7: a lone observed read yields valid data in the next cycle.
    assert_read_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_observe && !req_wr && !busy) |=> rsp_valid);
endmodule

// File: tb/mem_access_filter_test.sv
`timescale 1ns/1ps
module mem_access_filter_test;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_rd = 1'b0, req_wr = 1'b0, req_observe = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid, busy, mem_ce, mem_we;
    logic [DW-1:0] rsp_rdata;
    logic [CW-1:0] cnt_rd_fwd, cnt_rd_drop, cnt_wr_fwd, cnt_wr_drop;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [AW-1:0] A_A = 6'd5, A_B = 6'd9, A_C = 6'd12;

    always #2 clk = ~clk;

    mem_access_filter #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_observe(req_observe),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
        .mem_ce(mem_ce), .mem_we(mem_we),
        .cnt_rd_fwd(cnt_rd_fwd), .cnt_rd_drop(cnt_rd_drop),
        .cnt_wr_fwd(cnt_wr_fwd), .cnt_wr_drop(cnt_wr_drop)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one request at the falling edge, check enables, then pass the rising edge.
    task automatic step(input logic rd, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic obs,
                        input logic exp_ce, input logic exp_we, input string tag);
        @(negedge clk);
        req_rd = rd; req_wr = wr; req_addr = a; req_wdata = d; req_observe = obs;
        #1;
        check({tag, " mem_ce"}, 32'(mem_ce), 32'(exp_ce));
        check({tag, " mem_we"}, 32'(mem_we), 32'(exp_we));
        @(posedge clk);
        #1;
    endtask

    task automatic expect_rsp(input logic v, input logic [DW-1:0] dat, input string tag);
        check({tag, " rsp_valid"}, 32'(rsp_valid), 32'(v));
        if (v) check({tag, " rsp_rdata"}, 32'(rsp_rdata), 32'(dat));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 cnt_rd_fwd", 32'(cnt_rd_fwd), 0);
        check("R1 cnt_rd_drop", 32'(cnt_rd_drop), 0);
        check("R1 cnt_wr_fwd", 32'(cnt_wr_fwd), 0);
        check("R1 cnt_wr_drop", 32'(cnt_wr_drop), 0);
        check("R1 rsp_valid", 32'(rsp_valid), 0);
        check("R1 busy", 32'(busy), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_first();
        step(0, 1, A_A, 16'h1111, 0, 1, 1, "R1 first write");
        step(0, 1, A_B, 16'h2222, 0, 1, 1, "R6 new write");
        step(1, 0, A_A, '0, 1, 1, 0, "R1 first read");
        expect_rsp(1, 16'h1111, "R7 forwarded read");
    endtask

    task automatic t_repeat_read();
        step(1, 0, A_A, '0, 1, 0, 0, "R3 repeat read");
        expect_rsp(1, 16'h1111, "R7 dropped read data");
        step(1, 0, A_B, '0, 1, 1, 0, "R3 new address");
        expect_rsp(1, 16'h2222, "R7 read B");
        step(1, 0, A_B, '0, 1, 0, 0, "R3 repeat B");
        expect_rsp(1, 16'h2222, "R7 repeat B data");
        step(1, 0, A_A, '0, 1, 1, 0, "R3 back to A");
        expect_rsp(1, 16'h1111, "R7 read A again");
    endtask

    task automatic t_unobserved();
        step(1, 0, A_B, '0, 0, 0, 0, "R2 unobserved read");
        expect_rsp(0, '0, "R2 no response");
        step(1, 0, A_B, '0, 1, 1, 0, "R2 record unchanged");
        expect_rsp(1, 16'h2222, "R2 read B data");
    endtask

    task automatic t_invalidate();
        step(1, 0, A_B, '0, 1, 0, 0, "R4 repeat before write");
        step(0, 1, A_C, 16'h3333, 0, 1, 1, "R4 write C");
        step(1, 0, A_B, '0, 1, 1, 0, "R4 read after write");
        expect_rsp(1, 16'h2222, "R4 data B");
    endtask

    task automatic t_dup_write();
        step(0, 1, A_C, 16'h3333, 0, 0, 0, "R5 duplicate write");
        step(1, 0, A_C, '0, 1, 1, 0, "R5 read C");
        expect_rsp(1, 16'h3333, "R5 data C");
        step(0, 1, A_C, 16'h3333, 0, 0, 0, "R5 duplicate again");
        step(1, 0, A_C, '0, 1, 0, 0, "R11 read kept dropped");
        expect_rsp(1, 16'h3333, "R11 data C");
    endtask

    task automatic t_interleave();
        step(0, 1, A_A, 16'h4444, 0, 1, 1, "R6 write A");
        step(0, 1, A_B, 16'h5555, 0, 1, 1, "R6 write B");
        step(0, 1, A_A, 16'h4444, 0, 1, 1, "R6 A after B");
        step(0, 1, A_A, 16'h4444, 0, 0, 0, "R5 A repeat");
        step(0, 1, A_A, 16'h4445, 0, 1, 1, "R6 new data");
        step(1, 0, A_A, '0, 1, 1, 0, "R6 read A");
        expect_rsp(1, 16'h4445, "R6 data A");
    endtask

    task automatic t_collision();
        step(1, 1, A_B, 16'h6666, 1, 1, 1, "R8 collision write");
        check("R8 busy high", 32'(busy), 1);
        expect_rsp(0, '0, "R8 no data yet");
        step(0, 0, '0, '0, 0, 1, 0, "R8 deferred read");
        check("R8 busy low", 32'(busy), 0);
        expect_rsp(1, 16'h6666, "R8 deferred data");
    endtask

    task automatic t_busy_ignore();
        step(1, 1, A_C, 16'h7777, 1, 1, 1, "R9 collision");
        step(0, 1, A_A, 16'h9999, 0, 1, 0, "R9 write in busy");
        expect_rsp(1, 16'h7777, "R9 deferred data");
        step(1, 0, A_A, '0, 1, 1, 0, "R9 read A");
        expect_rsp(1, 16'h4445, "R9 A not written");
        step(0, 0, '0, '0, 0, 0, 0, "R9 idle");
    endtask

    task automatic t_counters();
        check("R10 cnt_rd_fwd", 32'(cnt_rd_fwd), 10);
        check("R10 cnt_rd_drop", 32'(cnt_rd_drop), 5);
        check("R10 cnt_wr_fwd", 32'(cnt_wr_fwd), 9);
        check("R10 cnt_wr_drop", 32'(cnt_wr_drop), 3);
    endtask

    initial begin
        t_reset();
        t_first();
        t_repeat_read();
        t_unobserved();
        t_invalidate();
        t_dup_write();
        t_interleave();
        t_collision();
        t_busy_ignore();
        t_counters();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule